// File: doc/BRIEF.md
# DRAM Start-up and Refresh Sequencer

This block sits on the controller side of an asynchronous 16-bit EDO DRAM and owns the row strobe, column strobe and write-enable lines whenever the memory is being woken or refreshed. After reset it keeps every strobe inactive for a power-up pause. It then runs a burst of wake-up refresh cycles and only after that declares the memory ready. From then on it issues periodic CAS-before-RAS refreshes and hands the bus to an accessor through a request/grant/done handshake. An access that is under way always completes before a refresh starts.

If an access holds the bus so long that the refresh interval is badly overrun, the block withdraws ready and replays the full wake-up burst. On request it refreshes every row in one burst and then parks the memory in self refresh: a CAS-before-RAS cycle whose row strobe stays low. When the request is dropped and the minimum hold has elapsed, it precharges and runs another full-row burst before any access is granted. Every duration is a parameter counted in clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: From reset, ras_n, cas_n and we_n stay high and ready, acc_gnt and in_selfref stay low for at least PAUSE_CYC cycles. The first column strobe falls no later than PAUSE_CYC+3 cycles after reset is released.
- R2: After the pause, exactly WAKE_CNT refresh cycles complete (row strobe rising edges) before ready rises.
- R3: Every refresh is CAS-before-RAS. cas_n is low for at least CSU_CYC cycles before ras_n falls. ras_n stays low for at least RAS_CYC cycles and high for at least PRE_CYC cycles between low periods. we_n stays high at all times.
- R4: With no access and no self-refresh request, successive refreshes start exactly REF_INT_CYC+2 cycles apart.
- R5: acc_gnt is given only while ready is high. It stays high until acc_done is seen and drops on the next cycle. All strobes are high while it is held. A refresh that falls due during an access starts after the access ends, and ready stays high if no lapse occurred.
- R6: If LAPSE_CYC cycles pass without a refresh start, ready drops once the bus is free. Exactly WAKE_CNT refresh cycles then complete before ready rises again.
- R7: No grant is given before the WAKE_CNT-th wake-up refresh has completed, even when acc_req is held high from reset.
- R8: A self-refresh request taken while ready causes exactly ROWS+1 row strobe falls. The last of these leaves ras_n and cas_n low with in_selfref high for at least SR_HOLD_CYC cycles, however early the request is dropped.
- R9: Once the request is low and the hold has elapsed, in_selfref drops and ras_n stays high for at least the larger of SR_EXIT_CYC and PRE_CYC. Exactly ROWS refresh cycles then start before the next grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Accessor asks for the memory |
| acc_done | input | 1 | Accessor has finished its access |
| sr_req | input | 1 | Level request to enter and stay in self refresh |
| acc_gnt | output | 1 | Memory handed to the accessor |
| ready | output | 1 | Wake-up sequence complete and refresh not lapsed |
| in_selfref | output | 1 | Memory parked in self refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |

## Verification
All outputs are decoded from the state register, so each one changes one clock edge after the state moves. A request seen in an idle cycle gives a grant on the next edge, and acc_done sampled at an edge removes the grant at that same edge. Refresh starts come REF_INT_CYC+2 edges apart, since the age counter needs one edge to flag the refresh and one to load the burst. The bench samples every output on the falling clock edge and drives inputs there as well. It measures strobe widths and gaps by counting those samples. Exact cycle counts are checked where the derivation is fixed: the refresh period, the self-refresh hold of SR_HOLD_CYC plus one exit cycle, and the wake and row burst lengths.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [3:0] {
    S_PAUSE, S_IDLE, S_GRANT, S_CSU, S_RASLO, S_PRE, S_SRHOLD, S_SRWAIT, S_SREXIT
  } seq_st_t;

  // value loaded into a dwell counter so that a state lasts n cycles
  function automatic int unsigned dwell_load(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_seq_timer.sv
module dram_seq_timer #(
  parameter int unsigned TW      = 16,
  parameter int unsigned RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= TW'(RST_VAL);
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/dram_seq_age.sv
module dram_seq_age #(
  parameter int unsigned REF_INT_CYC = 1950,
  parameter int unsigned LAPSE_CYC   = 3900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic ref_due,
  output logic lapsed
);
  localparam int unsigned AW = $clog2(LAPSE_CYC + 1);
  logic [AW-1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)                  age <= '0;
    else if (age != AW'(LAPSE_CYC))     age <= age + 1'b1;
  end

  assign ref_due = (age >= AW'(REF_INT_CYC));
  assign lapsed  = (age == AW'(LAPSE_CYC));
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_seq_pkg::*;
#(
  parameter int unsigned PAUSE_CYC   = 25000,
  parameter int unsigned WAKE_CNT    = 8,
  parameter int unsigned CSU_CYC     = 2,
  parameter int unsigned RAS_CYC     = 6,
  parameter int unsigned PRE_CYC     = 5,
  parameter int unsigned SR_HOLD_CYC = 13000,
  parameter int unsigned SR_EXIT_CYC = 15,
  parameter int unsigned ROWS        = 1024,
  parameter int unsigned REF_INT_CYC = 1950,
  parameter int unsigned LAPSE_CYC   = 3900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_req,
  input  logic acc_done,
  input  logic sr_req,
  output logic acc_gnt,
  output logic ready,
  output logic in_selfref,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int unsigned L_PAUSE = dwell_load(PAUSE_CYC);
  localparam int unsigned L_CSU   = dwell_load(CSU_CYC);
  localparam int unsigned L_RAS   = dwell_load(RAS_CYC);
  localparam int unsigned L_PRE   = dwell_load(PRE_CYC);
  localparam int unsigned L_HOLD  = dwell_load(SR_HOLD_CYC);
  localparam int unsigned L_EXIT  = dwell_load(umax(SR_EXIT_CYC, PRE_CYC));
  localparam int unsigned TMAX    = umax(umax(L_PAUSE, L_HOLD), umax(umax(L_CSU, L_RAS), umax(L_PRE, L_EXIT)));
  localparam int unsigned TW      = $clog2(TMAX + 2);
  localparam int unsigned BW      = $clog2(umax(ROWS + 1, WAKE_CNT) + 1);

  seq_st_t       st, st_nx;
  logic [BW-1:0] burst, burst_nx;
  logic          woke, woke_nx, sr_arm, arm_nx;
  logic          ld, expired, ref_due, lapsed;
  logic [TW-1:0] ld_val;

  // named internal events
  logic cbr_start, burst_last, sr_parked, age_clr;
  assign cbr_start  = (st == S_IDLE) && (burst != '0);
  assign burst_last = (burst == BW'(1));
  assign sr_parked  = (st == S_SRHOLD) || (st == S_SRWAIT);
  assign age_clr    = cbr_start || sr_parked || (st == S_SREXIT) || (st == S_PAUSE);

  dram_seq_timer #(.TW(TW), .RST_VAL(L_PAUSE)) u_dwell (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .expired(expired)
  );

  dram_seq_age #(.REF_INT_CYC(REF_INT_CYC), .LAPSE_CYC(LAPSE_CYC)) u_age (
    .clk(clk), .rst_n(rst_n), .clr(age_clr), .ref_due(ref_due), .lapsed(lapsed)
  );

  always_comb begin
    st_nx    = st;
    ld       = 1'b0;
    ld_val   = '0;
    burst_nx = burst;
    woke_nx  = woke;
    arm_nx   = sr_arm;
    unique case (st)
      S_PAUSE: if (expired) st_nx = S_IDLE;
      S_IDLE: begin
        if (cbr_start) begin
          st_nx = S_CSU; ld = 1'b1; ld_val = TW'(L_CSU);
        end else if (lapsed) begin
          woke_nx = 1'b0; burst_nx = BW'(WAKE_CNT);
        end else if (ref_due) begin
          burst_nx = BW'(1);
        end else if (woke && sr_req) begin
          burst_nx = BW'(ROWS + 1); arm_nx = 1'b1;
        end else if (woke && acc_req) begin
          st_nx = S_GRANT;
        end
      end
      S_GRANT: if (acc_done) st_nx = S_IDLE;
      S_CSU: if (expired) begin
        st_nx = S_RASLO; ld = 1'b1; ld_val = TW'(L_RAS);
      end
      S_RASLO: if (expired) begin
        if (sr_arm && burst_last) begin
          st_nx = S_SRHOLD; ld = 1'b1; ld_val = TW'(L_HOLD); burst_nx = '0;
        end else begin
          st_nx = S_PRE; ld = 1'b1; ld_val = TW'(L_PRE);
        end
      end
      S_PRE: if (expired) begin
        st_nx    = S_IDLE;
        burst_nx = burst - 1'b1;
        if (burst_last) woke_nx = 1'b1;
      end
      S_SRHOLD: if (expired) st_nx = S_SRWAIT;
      S_SRWAIT: if (!sr_req) begin
        st_nx = S_SREXIT; ld = 1'b1; ld_val = TW'(L_EXIT);
      end
      S_SREXIT: if (expired) begin
        st_nx = S_IDLE; burst_nx = BW'(ROWS); arm_nx = 1'b0;
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_PAUSE;
      burst  <= BW'(WAKE_CNT);
      woke   <= 1'b0;
      sr_arm <= 1'b0;
    end else begin
      st     <= st_nx;
      burst  <= burst_nx;
      woke   <= woke_nx;
      sr_arm <= arm_nx;
    end
  end

  always_comb begin
    ras_n      = !((st == S_RASLO) || sr_parked);
    cas_n      = !((st == S_CSU) || (st == S_RASLO) || sr_parked);
    we_n       = 1'b1;
    acc_gnt    = (st == S_GRANT);
    ready      = woke;
    in_selfref = sr_parked;
  end
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int unsigned PAUSE_CYC   = 25000,
  parameter int unsigned WAKE_CNT    = 8,
  parameter int unsigned CSU_CYC     = 2,
  parameter int unsigned RAS_CYC     = 6,
  parameter int unsigned PRE_CYC     = 5,
  parameter int unsigned SR_HOLD_CYC = 13000
) (
  input logic clk,
  input logic rst_n,
  input logic acc_done,
  input logic acc_gnt,
  input logic ready,
  input logic in_selfref,
  input logic ras_n,
  input logic cas_n,
  input logic cbr_start
);
  logic [31:0] since_rst, cas_lead, low_cnt, high_cnt, wake_rises;
  logic        ras_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_rst <= '0; cas_lead <= '0; low_cnt <= '0; high_cnt <= '0;
      wake_rises <= '0; ras_q <= 1'b1;
    end else begin
      ras_q <= ras_n;
      if (since_rst < PAUSE_CYC) since_rst <= since_rst + 1;
      cas_lead   <= (ras_n && !cas_n) ? cas_lead + 1 : 32'd0;
      low_cnt    <= ras_n ? 32'd0 : low_cnt + 1;
      high_cnt   <= ras_n ? high_cnt + 1 : 32'd0;
      if (ready)                 wake_rises <= '0;
      else if (ras_n && !ras_q)  wake_rises <= wake_rises + 1;
    end
  end

  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < PAUSE_CYC) |-> (ras_n && cas_n && !ready)); // R1
  AST_READY_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (wake_rises >= WAKE_CNT)); // R2
  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (cas_lead >= CSU_CYC)); // R3
  AST_CBR_START_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    cbr_start |=> !cas_n && ras_n); // R3
  AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (low_cnt >= RAS_CYC)); // R3
  AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (high_cnt >= PRE_CYC)); // R3
  AST_GNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt |-> (ready && ras_n && cas_n)); // R5
  AST_GNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_gnt && !acc_done) |=> acc_gnt); // R5
  AST_SR_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    in_selfref |-> (!ras_n && !cas_n)); // R8
  AST_SR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_selfref) |-> (low_cnt >= SR_HOLD_CYC)); // R8
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .PAUSE_CYC(PAUSE_CYC), .WAKE_CNT(WAKE_CNT), .CSU_CYC(CSU_CYC),
  .RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC), .SR_HOLD_CYC(SR_HOLD_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_done(acc_done), .acc_gnt(acc_gnt),
  .ready(ready), .in_selfref(in_selfref), .ras_n(ras_n), .cas_n(cas_n),
  .cbr_start(cbr_start)
);

// File: tb/dram_refresh_seq_test.sv
`timescale 1ns/1ps
module dram_refresh_seq_test;
  localparam int PAUSE = 40, WAKE = 8, CSU = 2, RASW = 4, PRE = 3;
  localparam int HOLD = 20, SREX = 6, ROWS = 4, RINT = 60, LAPSE = 150;

  logic clk = 0, rst_n = 0;
  logic acc_req = 0, acc_done = 0, sr_req = 0;
  logic acc_gnt, ready, in_selfref, ras_n, cas_n, we_n;

  int checks = 0, fails = 0;
  int cyc = 0, falls = 0, rises = 0, low_len = 0, high_len = 0, cas_lead = 0;
  int cbr_bad = 0, pre_bad = 0, width_bad = 0, we_bad = 0, gnt_bad = 0, early_gnt = 0;
  int first_cas = -1, last_fall = 0, prev_fall = 0;
  logic prev_ras = 1;

  always #4 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .WAKE_CNT(WAKE), .CSU_CYC(CSU), .RAS_CYC(RASW), .PRE_CYC(PRE),
    .SR_HOLD_CYC(HOLD), .SR_EXIT_CYC(SREX), .ROWS(ROWS), .REF_INT_CYC(RINT), .LAPSE_CYC(LAPSE)
  ) uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // output monitor on the falling edge
  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (first_cas < 0 && !cas_n) first_cas = cyc;
    if (prev_ras && !ras_n) begin
      falls++;
      if (cas_lead < CSU) cbr_bad++;
      if (high_len < PRE) pre_bad++;
      prev_fall = last_fall; last_fall = cyc;
    end
    if (!prev_ras && ras_n) begin
      rises++;
      if (low_len < RASW) width_bad++;
    end
    if (!we_n) we_bad++;
    if (acc_gnt && (!ras_n || !cas_n)) gnt_bad++;
    if (acc_gnt && rises < WAKE) early_gnt++;
    cas_lead = (ras_n && !cas_n) ? cas_lead + 1 : 0;
    low_len  = ras_n ? 0 : low_len + 1;
    high_len = ras_n ? high_len + 1 : 0;
    prev_ras = ras_n;
  end

  task automatic wait_rise();
    int r0 = rises;
    while (rises == r0) @(negedge clk);
  endtask

  task automatic finish_access();
    @(negedge clk) acc_done = 1;
    @(negedge clk) acc_done = 0;
  endtask

  task automatic t_reset();
    int bad = 0;
    for (int i = 0; i < PAUSE; i++) begin
      @(negedge clk);
      if (!ras_n || !cas_n || !we_n || ready || acc_gnt || in_selfref) bad++;
    end
    chk(bad == 0, "R1 quiet pause", bad, 0);
  endtask

  task automatic t_power_up();
    int r_at_ready;
    while (!ready) @(negedge clk);
    r_at_ready = rises;
    chk(first_cas >= PAUSE && first_cas <= PAUSE + 3, "R1 first strobe", first_cas, PAUSE + 1);
    chk(r_at_ready == WAKE, "R2 wake refreshes before ready", r_at_ready, WAKE);
    while (!acc_gnt) @(negedge clk);
    chk(rises == WAKE, "R7 refreshes before first grant", rises, WAKE);
    chk(early_gnt == 0, "R7 early grant", early_gnt, 0);
    acc_req = 0;
    finish_access();
    chk(acc_gnt == 0, "R5 grant released after done", acc_gnt, 0);
  endtask

  task automatic t_periodic();
    for (int k = 0; k < 3; k++) begin
      int f0 = falls;
      while (falls == f0) @(negedge clk);
      if (k > 0) chk(last_fall - prev_fall == RINT + 2, "R4 refresh period", last_fall - prev_fall, RINT + 2);
    end
  endtask

  task automatic t_access_defers();
    int f0;
    wait_rise();
    acc_req = 1;
    while (!acc_gnt) @(negedge clk);
    acc_req = 0;
    f0 = falls;
    repeat (70) @(negedge clk);
    chk(falls == f0 && acc_gnt, "R5 no refresh during access", falls - f0, 0);
    finish_access();
    chk(acc_gnt == 0, "R5 grant drops after done", acc_gnt, 0);
    repeat (15) @(negedge clk);
    chk(falls == f0 + 1, "R5 deferred refresh runs", falls - f0, 1);
    chk(ready == 1, "R5 ready kept", ready, 1);
  endtask

  task automatic t_lapse();
    int f0, r0;
    wait_rise();
    acc_req = 1;
    while (!acc_gnt) @(negedge clk);
    acc_req = 0;
    f0 = falls;
    repeat (200) @(negedge clk);
    chk(falls == f0, "R6 bus held", falls - f0, 0);
    finish_access();
    while (ready) @(negedge clk);
    r0 = rises;
    while (!ready) @(negedge clk);
    chk(rises - r0 == WAKE, "R6 wake burst replayed", rises - r0, WAKE);
  endtask

  task automatic t_selfref();
    int f0, f1, len = 0, gap = 0;
    wait_rise();
    f0 = falls;
    sr_req = 1;
    while (!in_selfref) @(negedge clk);
    chk(falls - f0 == ROWS + 1, "R8 row burst before park", falls - f0, ROWS + 1);
    chk(!ras_n && !cas_n, "R8 strobes low while parked", {ras_n, cas_n}, 0);
    sr_req = 0;
    acc_req = 1;
    while (in_selfref) begin len++; @(negedge clk); end
    chk(len >= HOLD && len <= HOLD + 2, "R8 minimum hold", len, HOLD + 1);
    f1 = falls;
    while (ras_n) begin gap++; @(negedge clk); end
    chk(gap >= SREX, "R9 exit precharge", gap, SREX);
    while (!acc_gnt) @(negedge clk);
    chk(falls - f1 == ROWS, "R9 row burst after exit", falls - f1, ROWS);
    acc_req = 0;
    finish_access();
  endtask

  task automatic t_rules();
    chk(cbr_bad == 0, "R3 CAS leads RAS", cbr_bad, 0);
    chk(width_bad == 0, "R3 RAS width", width_bad, 0);
    chk(pre_bad == 0, "R3 precharge", pre_bad, 0);
    chk(we_bad == 0, "R3 WE high", we_bad, 0);
    chk(gnt_bad == 0, "R5 strobes idle in grant", gnt_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    acc_req = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_power_up();
    t_periodic();
    t_access_defers();
    t_lapse();
    t_selfref();
    t_rules();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule